// File: doc/BRIEF.md
# Predicated Vector Gather-Load Sequencer

This block carries out one predicated gather of unsigned 16-bit values into a vector result. A caller presents a 64-bit scalar base, a vector of per-element offsets, a byte-granular predicate and four mode bits, then pulses `start`. Mode bits select the element width (32 or 64 bits), the offset width (32 or 64 bits), how a 32-bit offset grows to 64 bits (zero or sign extension), and whether the offset is doubled before it is added to the base.

The sequencer walks the elements from index 0 upwards. Each active element issues one read on a valid/ready request port. The sequencer then waits for the response, zero-extends the returned halfword into that element's lane and moves on. Inactive elements issue nothing and leave their lane at zero. When the base comes from the stack pointer, the base must be 16-byte aligned whenever any element is active. A violation raises an alignment error instead of performing any reads.

The control is a single state machine. Its states are IDLE, CHECK, SCAN, ISSUE, AWAIT, COMMIT, DONE and FAULT.
- IDLE goes to CHECK on `start`, capturing all operands.
- CHECK goes to FAULT on a misaligned stack-pointer base with an active element, and to SCAN otherwise.
- SCAN goes to ISSUE for an active element. For an inactive element it goes to COMMIT after the last element, or stays in SCAN for the next one.
- ISSUE goes to AWAIT on `req_ready`.
- AWAIT goes to COMMIT on `rsp_valid` for the last element, and to SCAN otherwise.
- COMMIT goes to DONE, DONE goes to IDLE, and FAULT goes to IDLE.

Top module: `gather_load_seq`

## Requirements
- R1: After reset, `busy`, `done`, `align_err` and `req_valid` are 0 and `result` is all zeros.
- R2: The request address is `base + (ext << s)`, where `s` is 1 when `scale_x2`=1 and 0 otherwise. `ext` is the element's full 64-bit lane when `wide_elem`=1 and `wide_off`=1. In every other case `ext` is the low 32 bits of the element's lane, zero-extended when `off_signed`=0 and sign-extended when `off_signed`=1. With `wide_elem`=0, lanes are 32 bits wide and `wide_off` has no effect.
- R3: Element e is active when predicate bit e*4 (32-bit elements) or e*8 (64-bit elements) is 1. Exactly one request is issued per active element, in ascending element order. There are VL/32 or VL/64 elements.
- R4: An inactive element issues no request and its lane in `result` is all zeros.
- R5: The lane of an active element holds the response halfword in its low 16 bits, with all higher bits of the lane zero.
- R6: `result` changes only in the cycle where `done` is 1. `done` is a one-cycle pulse, given once per completed operation.
- R7: When `base_is_sp`=1, at least one element is active and `base[3:0]` is not zero, the operation issues no request. It pulses `align_err` for one cycle, gives no `done`, and leaves `result` unchanged. With no active element, no alignment check is made and the operation completes with an all-zero result.
- R8: Once `req_valid` is 1, it stays 1 with `req_addr` unchanged until a cycle with `req_ready`=1.
- R9: `start` has no effect while `busy` is 1. Operands are captured only when `start` is seen with `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| base | input | 64 | Scalar base address |
| base_is_sp | input | 1 | Base comes from the stack pointer (enables alignment check) |
| offsets | input | VL | Per-element offset lanes |
| pred | input | VL/8 | Predicate, one bit per vector byte |
| wide_elem | input | 1 | 1: 64-bit elements, 0: 32-bit elements |
| wide_off | input | 1 | 1: 64-bit offsets (only with 64-bit elements) |
| off_signed | input | 1 | 32-bit offset extension: 0 zero, 1 sign |
| scale_x2 | input | 1 | Double the offset before adding |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 64 | Read request address |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 16 | Read response halfword |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| align_err | output | 1 | One-cycle stack-pointer alignment error pulse |
| result | output | VL | Assembled result vector |

## Verification
The assertions assume the memory returns exactly one `rsp_valid` pulse per accepted request, only while that read is outstanding. They also assume `rst_n` is low from time zero. The bench's memory model answers each accepted request once, after a latency of one to three cycles, and never raises `rsp_valid` otherwise. It varies `req_ready` so that the request-hold rule is exercised under stalls. Operands are changed only around `start` or, for the ignored-start case, deliberately during an operation, which the design must not notice.

// File: rtl/gather_pkg.sv
package gather_pkg;
    localparam int GADDR_W = 64;
    localparam int GHALF_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SCAN,
        ST_ISSUE,
        ST_AWAIT,
        ST_COMMIT,
        ST_DONE,
        ST_FAULT
    } gstate_t;

    typedef struct packed {
        logic wide_elem;
        logic wide_off;
        logic off_signed;
        logic scale_x2;
    } gmode_t;
endpackage

// File: rtl/gather_addr_gen.sv
module gather_addr_gen
    import gather_pkg::*;
#(
    parameter int VL = 256,
    localparam int N32 = VL / 32,
    localparam int N64 = VL / 64,
    localparam int IDX_W = $clog2(N32)
) (
    input  logic [VL-1:0]      offsets,
    input  logic [IDX_W-1:0]   idx,
    input  gmode_t             mode,
    input  logic [GADDR_W-1:0] base,
    output logic [GADDR_W-1:0] addr
);
    logic [31:0] lane32 [N32];
    logic [63:0] lane64 [N64];

    for (genvar i = 0; i < N32; i++) begin : g_l32
        assign lane32[i] = offsets[i*32 +: 32];
    end
    for (genvar j = 0; j < N64; j++) begin : g_l64
        assign lane64[j] = offsets[j*64 +: 64];
    end

    logic [31:0] sel32;
    logic [63:0] sel64;
    logic [31:0] low;
    logic [63:0] ext;

    always_comb begin
        sel32 = lane32[idx];
        sel64 = lane64[idx[IDX_W-2:0]];
        low   = mode.wide_elem ? sel64[31:0] : sel32;
        if (mode.wide_elem && mode.wide_off) begin
            ext = sel64;
        end else if (mode.off_signed) begin
            ext = {{32{low[31]}}, low};
        end else begin
            ext = {32'b0, low};
        end
        addr = base + (mode.scale_x2 ? {ext[62:0], 1'b0} : ext);
    end
endmodule

// File: rtl/gather_pred_scan.sv
module gather_pred_scan #(
    parameter int VL = 256,
    localparam int N32 = VL / 32,
    localparam int N64 = VL / 64,
    localparam int IDX_W = $clog2(N32)
) (
    input  logic [VL/8-1:0]  pred,
    input  logic             wide_elem,
    input  logic [IDX_W-1:0] idx,
    output logic             cur_active,
    output logic             any_active,
    output logic             last
);
    logic [N32-1:0] act32;
    logic [N64-1:0] act64;

    for (genvar i = 0; i < N32; i++) begin : g_a32
        assign act32[i] = pred[i*4];
    end
    for (genvar j = 0; j < N64; j++) begin : g_a64
        assign act64[j] = pred[j*8];
    end

    always_comb begin
        if (wide_elem) begin
            cur_active = act64[idx[IDX_W-2:0]];
            any_active = |act64;
            last       = (idx == IDX_W'(N64 - 1));
        end else begin
            cur_active = act32[idx];
            any_active = |act32;
            last       = (idx == IDX_W'(N32 - 1));
        end
    end
endmodule

// File: rtl/gather_lane_writer.sv
module gather_lane_writer
    import gather_pkg::*;
#(
    parameter int VL = 256,
    localparam int N32 = VL / 32,
    localparam int IDX_W = $clog2(N32)
) (
    input  logic [VL-1:0]      work,
    input  logic [IDX_W-1:0]   idx,
    input  logic               wide_elem,
    input  logic [GHALF_W-1:0] data,
    output logic [VL-1:0]      work_next
);
    for (genvar s = 0; s < N32; s++) begin : g_slot
        localparam logic [IDX_W-1:0] SELF = IDX_W'(s);
        localparam logic [IDX_W-1:0] HALF = IDX_W'(s / 2);
        localparam bit               ODD  = (s % 2) == 1;
        logic hit_lo;
        logic hit_hi;
        always_comb begin
            if (wide_elem) begin
                hit_lo = !ODD && (idx == HALF);
                hit_hi = ODD && (idx == HALF);
            end else begin
                hit_lo = (idx == SELF);
                hit_hi = 1'b0;
            end
            if (hit_lo) begin
                work_next[s*32 +: 32] = {16'b0, data};
            end else if (hit_hi) begin
                work_next[s*32 +: 32] = 32'b0;
            end else begin
                work_next[s*32 +: 32] = work[s*32 +: 32];
            end
        end
    end
endmodule

// File: rtl/gather_load_seq.sv
module gather_load_seq
    import gather_pkg::*;
#(
    parameter int VL = 256,
    parameter int SP_ALIGN = 16,
    localparam int N32 = VL / 32,
    localparam int IDX_W = $clog2(N32),
    localparam int AL_W = $clog2(SP_ALIGN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [63:0]     base,
    input  logic            base_is_sp,
    input  logic [VL-1:0]   offsets,
    input  logic [VL/8-1:0] pred,
    input  logic            wide_elem,
    input  logic            wide_off,
    input  logic            off_signed,
    input  logic            scale_x2,
    output logic            req_valid,
    input  logic            req_ready,
    output logic [63:0]     req_addr,
    input  logic            rsp_valid,
    input  logic [15:0]     rsp_data,
    output logic            busy,
    output logic            done,
    output logic            align_err,
    output logic [VL-1:0]   result
);
    gstate_t state, state_nxt;

    logic [63:0]     base_q;
    logic            sp_q;
    logic [VL-1:0]   offs_q;
    logic [VL/8-1:0] pred_q;
    gmode_t          mode_q;
    logic [IDX_W-1:0] idx_q;
    logic [VL-1:0]   work_q;
    logic [VL-1:0]   res_q;

    logic            cur_active;
    logic            any_active;
    logic            last;
    logic [63:0]     addr;
    logic [VL-1:0]   work_next;
    logic            misaligned;

    assign misaligned = |base_q[AL_W-1:0];

    gather_addr_gen #(.VL(VL)) u_addr (
        .offsets (offs_q),
        .idx     (idx_q),
        .mode    (mode_q),
        .base    (base_q),
        .addr    (addr)
    );

    gather_pred_scan #(.VL(VL)) u_scan (
        .pred       (pred_q),
        .wide_elem  (mode_q.wide_elem),
        .idx        (idx_q),
        .cur_active (cur_active),
        .any_active (any_active),
        .last       (last)
    );

    gather_lane_writer #(.VL(VL)) u_lane (
        .work      (work_q),
        .idx       (idx_q),
        .wide_elem (mode_q.wide_elem),
        .data      (rsp_data),
        .work_next (work_next)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (start) state_nxt = ST_CHECK;
            ST_CHECK:  state_nxt = (sp_q && any_active && misaligned) ? ST_FAULT : ST_SCAN;
            ST_SCAN:   begin
                if (cur_active) state_nxt = ST_ISSUE;
                else if (last)  state_nxt = ST_COMMIT;
            end
            ST_ISSUE:  if (req_ready) state_nxt = ST_AWAIT;
            ST_AWAIT:  if (rsp_valid) state_nxt = last ? ST_COMMIT : ST_SCAN;
            ST_COMMIT: state_nxt = ST_DONE;
            ST_DONE:   state_nxt = ST_IDLE;
            ST_FAULT:  state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // Operand capture, element walk and lane assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            sp_q   <= 1'b0;
            offs_q <= '0;
            pred_q <= '0;
            mode_q <= '0;
            idx_q  <= '0;
            work_q <= '0;
            res_q  <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                base_q <= base;
                sp_q   <= base_is_sp;
                offs_q <= offsets;
                pred_q <= pred;
                mode_q <= '{wide_elem: wide_elem,
                            wide_off: wide_elem & wide_off,
                            off_signed: off_signed,
                            scale_x2: scale_x2};
                idx_q  <= '0;
                work_q <= '0;
            end
            if ((state == ST_SCAN && !cur_active) || (state == ST_AWAIT && rsp_valid)) begin
                if (!last) idx_q <= idx_q + 1'b1;
            end
            if (state == ST_AWAIT && rsp_valid) work_q <= work_next;
            if (state == ST_COMMIT) res_q <= work_q;
        end
    end

    // Outputs
    always_comb begin
        req_valid = (state == ST_ISSUE);
        req_addr  = addr;
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        align_err = (state == ST_FAULT);
        result    = res_q;
    end

    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_result_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    p_done_xor_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && align_err));

    p_fault_from_check_r7: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> $past(state == ST_CHECK));

    p_req_when_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy);
endmodule

// File: tb/gather_load_seq_tb.sv
module gather_load_seq_tb;
    localparam int VL  = 256;
    localparam int N32 = VL / 32;
    localparam int N64 = VL / 64;
    localparam int PW  = VL / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          start = 0;
    logic [63:0]   base = 0;
    logic          base_is_sp = 0;
    logic [VL-1:0] offsets = '0;
    logic [PW-1:0] pred = '0;
    logic          wide_elem = 0, wide_off = 0, off_signed = 0, scale_x2 = 0;
    logic          req_valid, req_ready;
    logic [63:0]   req_addr;
    logic          rsp_valid;
    logic [15:0]   rsp_data;
    logic          busy, done, align_err;
    logic [VL-1:0] result;

    gather_load_seq #(.VL(VL)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base(base), .base_is_sp(base_is_sp),
        .offsets(offsets), .pred(pred), .wide_elem(wide_elem), .wide_off(wide_off),
        .off_signed(off_signed), .scale_x2(scale_x2), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .busy(busy), .done(done), .align_err(align_err),
        .result(result)
    );

    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        logic          fault;
        logic [VL-1:0] res;
        string         tag;
    } exp_t;

    logic [63:0]   exp_addr_q [$];
    exp_t          exp_q [$];
    logic [VL-1:0] prev_res = '0;

    task automatic chk(input bit ok, input string tag, input logic [VL-1:0] act,
                       input logic [VL-1:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [15:0] memf(input logic [63:0] a);
        return a[16:1] ^ a[47:32] ^ 16'h3C5A;
    endfunction

    function automatic logic [63:0] calc_addr(input logic [63:0] b, input logic [63:0] v,
                                              input logic we, wo, sg, sc);
        logic [63:0] o;
        if (we && wo)    o = v;
        else if (sg)     o = {{32{v[31]}}, v[31:0]};
        else             o = {32'b0, v[31:0]};
        return b + (sc ? (o << 1) : o);
    endfunction

    // Memory model: checks each accepted address against the scoreboard
    int mem_ctr = 0;
    int pend = 0;
    logic [63:0] pend_addr = 0;
    initial begin
        req_ready = 0;
        rsp_valid = 0;
        rsp_data  = 0;
        forever begin
            @(negedge clk);
            rsp_valid = 0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    rsp_valid = 1;
                    rsp_data  = memf(pend_addr);
                end
            end
            mem_ctr++;
            req_ready = (mem_ctr % 3) != 1;
            if (req_valid && req_ready && pend == 0 && !rsp_valid) begin
                pend_addr = req_addr;
                pend = 1 + (mem_ctr % 3);
                if (exp_addr_q.size() == 0) begin
                    chk(0, "R4 unexpected request", VL'(req_addr), '0);
                end else begin
                    logic [63:0] ea;
                    ea = exp_addr_q.pop_front();
                    chk(req_addr == ea, "R2/R3 request address", VL'(req_addr), VL'(ea));
                end
            end else if (req_valid && pend == 0 && !rsp_valid) begin
                req_ready = 0;
            end else begin
                req_ready = 0;
            end
        end
    end

    // Result monitor
    initial begin
        forever begin
            @(negedge clk);
            if (done || align_err) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R6 unexpected completion", result, '0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(align_err == e.fault && done == !e.fault,
                        {e.tag, " completion kind (R7)"}, VL'(align_err), VL'(e.fault));
                    chk(result == e.res, {e.tag, " result"}, result, e.res);
                end
            end
        end
    end

    task automatic run_op(input logic [63:0] b, input logic sp, input logic [VL-1:0] offs,
                          input logic [PW-1:0] pr, input logic we, wo, sg, sc,
                          input bit poke, input string tag);
        exp_t e;
        logic [VL-1:0] r;
        bit anyact;
        bit fault;
        int n;
        int g;
        r = '0;
        anyact = 0;
        n = we ? N64 : N32;
        for (int i = 0; i < n; i++) begin
            if (pr[i * (we ? 8 : 4)]) anyact = 1;
        end
        fault = sp && anyact && (b[3:0] != 4'h0);
        if (!fault) begin
            for (int i = 0; i < n; i++) begin
                if (pr[i * (we ? 8 : 4)]) begin
                    logic [63:0] a;
                    logic [63:0] v;
                    v = we ? offs[i*64 +: 64] : {32'b0, offs[i*32 +: 32]};
                    a = calc_addr(b, v, we, wo, sg, sc);
                    exp_addr_q.push_back(a);
                    if (we) r[i*64 +: 64] = {48'b0, memf(a)};
                    else    r[i*32 +: 32] = {16'b0, memf(a)};
                end
            end
        end
        e.fault = fault;
        e.res   = fault ? prev_res : r;
        e.tag   = tag;
        if (!fault) prev_res = r;
        exp_q.push_back(e);

        @(negedge clk);
        base = b; base_is_sp = sp; offsets = offs; pred = pr;
        wide_elem = we; wide_off = wo; off_signed = sg; scale_x2 = sc;
        start = 1;
        @(negedge clk);
        start = 0;
        if (poke) begin
            repeat (3) @(negedge clk);
            offsets = ~offs;
            base = b + 64'h40;
            pred = ~pr;
            start = 1;
            @(negedge clk);
            start = 0;
        end
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!(done || align_err) && g < 2000);
        chk(g < 2000, {tag, " completes"}, VL'(g), '0);
        @(negedge clk);
        chk(exp_addr_q.size() == 0, {tag, " R3 all requests issued"}, VL'(exp_addr_q.size()), '0);
        chk(exp_q.size() == 0, {tag, " R6 one completion"}, VL'(exp_q.size()), '0);
        exp_addr_q.delete();
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [VL-1:0] o;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !align_err && !req_valid, "R1 reset outputs",
            VL'({busy, done, align_err, req_valid}), '0);
        chk(result == '0, "R1 reset result", result, '0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R2/R5: 32-bit elements, zero-extended, unscaled, all active
        for (int i = 0; i < N32; i++) o[i*32 +: 32] = 32'h0001_0000 * i + 32'h10 * i + 32'h8000_0003;
        run_op(64'h0000_1234_0000_1000, 0, o, '1, 0, 0, 0, 0, 0, "R2 r5_zext32");
        // R2: sign-extended, scaled, wide_off ignored with 32-bit lanes
        run_op(64'h0000_0000_8000_0000, 0, o, '1, 0, 1, 1, 1, 0, "R2 sext32_scaled");
        // R4: partial predicate, 32-bit elements
        run_op(64'h0000_0000_0040_0000, 0, o, 32'h0F0F_0F0F, 0, 0, 1, 0, 0, "R4 partial32");
        // R3: non-lowest predicate bits only, so every element inactive
        run_op(64'h100, 0, o, 32'hEEEE_EEEE, 0, 0, 0, 0, 0, "R3 upper_bits_only");
        // R2: 64-bit elements, 64-bit offsets, scaled
        for (int j = 0; j < N64; j++) o[j*64 +: 64] = 64'hF000_0000_0000_0001 + 64'h1_0000_0101 * j;
        run_op(64'h0000_0010_0000_0000, 0, o, '1, 1, 1, 0, 1, 0, "R2 r5_off64");
        // R3/R4: 64-bit elements, 32-bit signed offsets, mixed predicate
        run_op(64'h2000, 0, o, 32'h0101_0001 | 32'hFE00_FE00, 1, 0, 1, 0, 0, "R3 r4_elem64_mixed");
        // R7: stack pointer base, aligned
        run_op(64'h7FF0, 1, o, '1, 1, 0, 0, 0, 0, "R7 sp_aligned");
        // R7: stack pointer base, misaligned with active element -> fault
        run_op(64'h7FF8, 1, o, 32'h0000_0100, 1, 0, 0, 0, 0, "R7 sp_misaligned");
        // R7: misaligned but nothing active -> completes, zero result
        run_op(64'h7FF2, 1, o, 32'h0000_0000, 1, 0, 0, 0, 0, "R7 sp_noactive");
        // R7: misaligned base not from stack pointer -> normal
        run_op(64'h7FF2, 0, o, 32'h1111_1111, 0, 0, 0, 1, 0, "R7 nonsp_misaligned");
        // R9: start while busy ignored, operand changes ignored
        run_op(64'h9000, 0, o, '1, 0, 0, 0, 1, 1, "R9 start_busy");
        // R8: req_ready stalls occur via the memory model throughout
        run_op(64'hFFFF_FFFF_FFFF_FFF0, 0, o, '1, 1, 1, 0, 0, 0, "R8 wrap_addr");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule